// File: doc/BRIEF.md
# DMA Channel Control and Completion Tracker

This block keeps the control and status bits of one DMA channel and decides when its programmed transfer count has run out. Software writes and reads a 4-bit control word holding a channel enable, an interrupt enable, a completion flag and a self-clearing queue-flush command. The datapath supplies a per-transfer strobe. A down-counter is loaded with the number of transfers and counts each strobe that lands while the channel is running.

The block tells the datapath whether the channel may run (`active_o`). It raises a level completion interrupt, and it emits a one-cycle flush pulse that empties the channel's pending request queue and any latched external requests. A non-maskable interrupt or an address error stops the channel and is held until software writes the enable to 0. Dropping the global master enable also stops the channel. None of these stops counts as a completion.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the control word reads 0, the counter is 0, and `active_o`, `irq_o` and `qclr_o` are all 0.
- R2: Control word layout: bit 0 is the channel enable and bit 2 is the interrupt enable. Both are written by any write and read back as written. Bit 1 is the completion flag. Bit 3 is the flush command and always reads 0.
- R3: A write with bit 3 = 1 while `demand_mode_i` and `bus_mode_i` are both 1 makes `qclr_o` high for exactly the cycle after the write. A write with bit 3 = 0, or with either mode input at 0, gives no pulse.
- R4: `active_o` is 1 only when the enable is 1, `master_en_i` is 1, the completion flag is 0, no abort is latched, and neither `nmi_i` nor `addr_err_i` is high.
- R5: `cnt_load_i` loads `cnt_val_i` and takes priority over counting. Each `xfer_done_i` seen while `active_o` is 1 and the count is nonzero lowers the count by one. Otherwise the count holds.
- R6: When a strobe brings the count from 1 to 0, the completion flag becomes 1 one clock after the count reaches 0.
- R7: A pulse on `nmi_i` or `addr_err_i` latches an abort that keeps the channel inactive. A write with bit 0 = 0 clears it. Strobes during an abort leave the count and the completion flag unchanged.
- R8: A write with bit 1 = 0 clears the completion flag only if the flag was read as 1 (`rd_en_i`) since it was set. A write with bit 1 = 1 leaves the flag unchanged.
- R9: While the completion flag is 1, `active_o` stays 0 even with the enable and master enable at 1.
- R10: `irq_o` is a level that is 1 exactly when both the interrupt enable and the completion flag are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 4 | Control word write data |
| rd_en_i | input | 1 | Control word read strobe (arms flag clearing) |
| rd_data_o | output | 4 | Control word read data |
| cnt_load_i | input | 1 | Load the transfer counter |
| cnt_val_i | input | CNT_W | Transfer count to load |
| xfer_done_i | input | 1 | One transfer completed |
| nmi_i | input | 1 | Non-maskable interrupt abort |
| addr_err_i | input | 1 | Address error abort |
| master_en_i | input | 1 | Global DMA master enable |
| demand_mode_i | input | 1 | Global on-demand transfer mode bit |
| bus_mode_i | input | 1 | Global bus mode bit |
| active_o | output | 1 | Channel may transfer |
| irq_o | output | 1 | Completion interrupt request |
| qclr_o | output | 1 | One-cycle request queue flush |
| cnt_o | output | CNT_W | Current transfer count |

## Verification
Several rules are checked on every cycle: the channel is never active under an abort input, a dropped master enable or a set completion flag. The counter moves down by exactly one per counted strobe. The completion flag only rises after the count has sat at zero. A flush pulse only follows a qualifying write. The bench scenarios cover the rest: the flush mode truth table, the one-clock delay from count expiry to the flag, the read-before-clear rule for the flag, and the abort latch persisting until the enable is written low.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned EN_B   = 0;
  localparam int unsigned DONE_B = 1;
  localparam int unsigned IE_B   = 2;
  localparam int unsigned QCLR_B = 3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             expire_i,
  input  logic             qmode_ok_i,
  output logic             en_o,
  output logic             ie_o,
  output logic             done_o,
  output logic             qclr_o
);
  logic en_q, ie_q, done_q, seen_q, qclr_q;
  logic done_clr;

  // flag clears only after software has observed it set
  assign done_clr = wr_en_i && !wr_data_i[DONE_B] && seen_q && done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
      seen_q <= 1'b0;
      qclr_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        en_q <= wr_data_i[EN_B];
        ie_q <= wr_data_i[IE_B];
      end
      if (expire_i) begin
        done_q <= 1'b1;
        seen_q <= 1'b0;
      end else if (done_clr) begin
        done_q <= 1'b0;
        seen_q <= 1'b0;
      end else if (rd_en_i && done_q) begin
        seen_q <= 1'b1;
      end
      qclr_q <= wr_en_i && wr_data_i[QCLR_B] && qmode_ok_i;
    end
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign done_o = done_q;
  assign qclr_o = qclr_q;
endmodule

// File: rtl/dma_chan_cnt.sv
module dma_chan_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             nz;

  assign nz = |cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (load_i)          cnt_q <= val_i;
      else if (dec_i && nz) cnt_q <= cnt_q - ONE;
      // registered so the flag lands one clock after zero
      exp_q <= !load_i && dec_i && (cnt_q == ONE);
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [CTL_W-1:0] rd_data_o,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             xfer_done_i,
  input  logic             nmi_i,
  input  logic             addr_err_i,
  input  logic             master_en_i,
  input  logic             demand_mode_i,
  input  logic             bus_mode_i,
  output logic             active_o,
  output logic             irq_o,
  output logic             qclr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic en, ie, done, expire, abort_q, abort_in;

  assign abort_in = nmi_i || addr_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              abort_q <= 1'b0;
    else if (abort_in)                        abort_q <= 1'b1;
    else if (wr_en_i && !wr_data_i[EN_B])     abort_q <= 1'b0;
  end

  dma_chan_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .expire_i   (expire),
    .qmode_ok_i (demand_mode_i && bus_mode_i),
    .en_o       (en),
    .ie_o       (ie),
    .done_o     (done),
    .qclr_o     (qclr_o)
  );

  assign active_o = en && master_en_i && !done && !abort_q && !abort_in;

  dma_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cnt_load_i),
    .val_i    (cnt_val_i),
    .dec_i    (active_o && xfer_done_i),
    .cnt_o    (cnt_o),
    .expire_o (expire)
  );

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[EN_B]   = en;
    rd_data_o[DONE_B] = done;
    rd_data_o[IE_B]   = ie;
  end

  assign irq_o = ie && done;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CTL_W-1:0] wr_data_i,
  input logic [CTL_W-1:0] rd_data_o,
  input logic             cnt_load_i,
  input logic             xfer_done_i,
  input logic             nmi_i,
  input logic             addr_err_i,
  input logic             master_en_i,
  input logic             demand_mode_i,
  input logic             bus_mode_i,
  input logic             active_o,
  input logic             irq_o,
  input logic             qclr_o,
  input logic [CNT_W-1:0] cnt_o
);
  a_r3_qclr_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qclr_o |-> $past(wr_en_i && wr_data_i[QCLR_B] && demand_mode_i && bus_mode_i));

  a_r4_abort_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i || addr_err_i || !master_en_i) |-> !active_o);

  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && xfer_done_i && !cnt_load_i && cnt_o != '0)
      |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  a_r6_done_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[DONE_B]) |-> $past(cnt_o) == '0);

  a_r8_write1_keeps_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[DONE_B] && rd_data_o[DONE_B]) |=> rd_data_o[DONE_B]);

  a_r9_done_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DONE_B] |-> !active_o);

  a_r10_irq_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[DONE_B]);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .cnt_load_i(cnt_load_i), .xfer_done_i(xfer_done_i),
  .nmi_i(nmi_i), .addr_err_i(addr_err_i), .master_en_i(master_en_i),
  .demand_mode_i(demand_mode_i), .bus_mode_i(bus_mode_i), .active_o(active_o),
  .irq_o(irq_o), .qclr_o(qclr_o), .cnt_o(cnt_o)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 0, rd_en_i = 0, cnt_load_i = 0, xfer_done_i = 0;
  logic nmi_i = 0, addr_err_i = 0, master_en_i = 0, demand_mode_i = 0, bus_mode_i = 0;
  logic [3:0] wr_data_i = '0;
  logic [CNT_W-1:0] cnt_val_i = '0;
  logic [3:0] rd_data_o;
  logic active_o, irq_o, qclr_o;
  logic [CNT_W-1:0] cnt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_chan_ctl #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .cnt_load_i(cnt_load_i),
    .cnt_val_i(cnt_val_i), .xfer_done_i(xfer_done_i), .nmi_i(nmi_i),
    .addr_err_i(addr_err_i), .master_en_i(master_en_i),
    .demand_mode_i(demand_mode_i), .bus_mode_i(bus_mode_i),
    .active_o(active_o), .irq_o(irq_o), .qclr_o(qclr_o), .cnt_o(cnt_o)
  );

  // {demand, bus, write bit3, expected pulse}
  localparam logic [3:0] QVEC [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1000, 4'b1010, 4'b1100, 4'b1111
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] d);
    wr_en_i = 1; wr_data_i = d;
    step();
    wr_en_i = 0; wr_data_i = '0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1;
    step();
    chk("R1 ctl", rd_data_o, 0);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 outs", {active_o, irq_o, qclr_o}, 0);

    for (int i = 0; i < 8; i++) begin
      demand_mode_i = QVEC[i][3];
      bus_mode_i    = QVEC[i][2];
      wr({QVEC[i][1], 3'b000});
      chk($sformatf("R3 pulse vec%0d", i), qclr_o, QVEC[i][0]);
      chk("R2 bit3 reads 0", rd_data_o[3], 0);
      step();
      chk($sformatf("R3 one cycle vec%0d", i), qclr_o, 0);
    end
    demand_mode_i = 0; bus_mode_i = 0;

    master_en_i = 1;
    cnt_load_i = 1; cnt_val_i = 3;
    step();
    cnt_load_i = 0;
    chk("R5 load", cnt_o, 3);
    wr(4'h5);
    chk("R2 readback", rd_data_o, 4'h5);
    chk("R4 active", active_o, 1);

    master_en_i = 0; #1;
    chk("R4 master off", active_o, 0);
    xfer_done_i = 1; step(); xfer_done_i = 0;
    chk("R5 hold inactive", cnt_o, 3);
    master_en_i = 1;

    xfer_done_i = 1;
    step(); chk("R5 dec", cnt_o, 2);
    step(); chk("R5 dec", cnt_o, 1);
    step(); chk("R5 dec", cnt_o, 0);
    xfer_done_i = 0;
    chk("R6 not yet", rd_data_o[1], 0);
    chk("R6 still active", active_o, 1);
    step();
    chk("R6 done set", rd_data_o[1], 1);
    chk("R9 blocked", active_o, 0);
    chk("R10 irq", irq_o, 1);

    wr(4'h5);
    chk("R8 unread keep", rd_data_o[1], 1);
    rd_en_i = 1; step(); rd_en_i = 0;
    wr(4'h7);
    chk("R8 write1 keep", rd_data_o[1], 1);
    chk("R9 blocked en1", active_o, 0);
    wr(4'h5);
    chk("R8 cleared", rd_data_o[1], 0);
    chk("R10 irq drop", irq_o, 0);
    chk("R4 reactive", active_o, 1);

    wr(4'h1);
    cnt_load_i = 1; cnt_val_i = 2; step(); cnt_load_i = 0;
    xfer_done_i = 1; step();
    chk("R5 dec2", cnt_o, 1);
    nmi_i = 1; #1;
    chk("R4 nmi", active_o, 0);
    step(); nmi_i = 0; #1;
    chk("R7 hold on nmi", cnt_o, 1);
    chk("R7 latched", active_o, 0);
    step(); step();
    xfer_done_i = 0;
    step();
    chk("R7 cnt frozen", cnt_o, 1);
    chk("R7 no done", rd_data_o[1], 0);

    wr(4'h0); wr(4'h1);
    chk("R7 rearm", active_o, 1);
    addr_err_i = 1; step(); addr_err_i = 0; #1;
    chk("R7 addr err latched", active_o, 0);
    wr(4'h0); wr(4'h1);
    xfer_done_i = 1; step(); xfer_done_i = 0;
    chk("R5 to zero", cnt_o, 0);
    step();
    chk("R6 done2", rd_data_o[1], 1);
    chk("R10 irq masked", irq_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule